// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block sits on the host side of a configuration path and loads a bitstream into one or more programmable devices that share a serial configuration chain. Stream words of a parameterised width arrive on a ready/valid port. The block sends them out one bit at a time on a single data line, which enters only the first device. It also drives one configuration clock that reaches every device in the chain.

The block watches two lines from the chain. The first is the init line. It goes high when the devices are ready, and a low level during loading reports a fault. The second is the done line, which reports that configuration is complete. After a start pulse the block waits for the init line to go high. It then lets a settling time of at least a set number of microseconds pass, converting that time to system cycles from a clock-frequency parameter, before it issues any clock edge. It then streams every word, most significant bit first.

After the word flagged as last, the block keeps pulsing the clock with the data line held high. It stops when the done line rises or when a pulse budget runs out. The result is shown as ok, timeout or error status, which stays until the next start. A counter reports how many words were accepted.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset and before any start, cfg_clk is low, cfg_dout is high, s_ready, busy, ok, err and timeout are low, and word_cnt is zero.
- R2: After a start, no rising edge appears on cfg_clk until cfg_init has been high.
- R3: The first rising edge of cfg_clk after a start comes at least SETTLE_CYC system cycles after cfg_init was first seen high. SETTLE_CYC is ceil(CLK_HZ/1e6)*SETTLE_US, which is 800 for the default values.
- R4: Each accepted word is sent on cfg_dout, one bit per rising edge of cfg_clk, most significant bit first. Every word gets exactly WORD_W rising edges.
- R5: cfg_dout changes only while cfg_clk is low. Two rising edges of cfg_clk are always at least 2*HALF_DIV system cycles apart.
- R6: s_ready is high only while cfg_clk is low and every bit of the previous word has been clocked. Two accepted words are separated by exactly WORD_W rising edges, and word_cnt counts the accepted words.
- R7: If cfg_init goes low while loading, err goes high, busy and s_ready go low, and cfg_clk stays low with no further rising edge.
- R8: err stays high, even after cfg_init returns high, until start is asserted. Start clears it.
- R9: After the last word (s_last high when the word is accepted), cfg_clk keeps pulsing with cfg_dout high until cfg_done is seen high, and then ok goes high. At most one of ok, err and timeout is high at a time.
- R10: If cfg_done stays low, exactly DONE_TIMEOUT clock pulses follow the last data bit. Then timeout goes high and stays high until the next start.
- R11: A start pulse in any state returns the block to waiting for cfg_init. It clears ok, err, timeout and word_cnt and raises busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts or restarts a load sequence |
| s_valid | input | 1 | Stream word valid |
| s_data | input | WORD_W | Stream word |
| s_last | input | 1 | Marks the final word of the stream |
| s_ready | output | 1 | Block can take a word |
| cfg_init | input | 1 | Device init line (high = ready, low = fault) |
| cfg_done | input | 1 | Device done line |
| cfg_clk | output | 1 | Shared configuration clock |
| cfg_dout | output | 1 | Serial data to the first device in the chain |
| busy | output | 1 | A sequence is in progress |
| ok | output | 1 | Configuration finished with done seen |
| err | output | 1 | Init fell during loading (latched) |
| timeout | output | 1 | Done never rose within the pulse budget |
| word_cnt | output | CNT_W | Number of words accepted since start |

## Verification
Directed streams of all-zero, all-one and edge-bit words show whether the bit order is correct and whether a bit is dropped or repeated at a word boundary. Randomised streams with random gaps between words and a random moment for the done line show that the handshake holds off a new word until the current one has been shifted out, and that the flush stops exactly when done is seen. One run never raises done, which separates the timeout path from the ok path by counting the flush pulses. Another run drops the init line in the middle of a word, which shows that clocking stops at once and that the error persists until a restart.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_INIT,
    ST_SETTLE,
    ST_LOAD,
    ST_SHIFT,
    ST_FLUSH,
    ST_FIN_OK,
    ST_FIN_TO,
    ST_FAULT
  } ld_state_t;

  // Settling delay in system cycles, rounded up per microsecond.
  function automatic int unsigned settle_cycles(input int unsigned hz, input int unsigned us);
    return ((hz + 999_999) / 1_000_000) * us;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/cfg_pace.sv
module cfg_pace #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic cfg_clk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div;
  logic          clk_q;
  logic          term;

  assign term = (div == DW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div   <= '0;
      clk_q <= 1'b0;
    end else if (term) begin
      div   <= '0;
      clk_q <= ~clk_q;
    end else begin
      div <= div + 1'b1;
    end
  end

  assign cfg_clk  = clk_q;
  assign rise_evt = run && term && !clk_q;
  assign fall_evt = run && term && clk_q;
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] data,
  input  logic         shift,
  output logic         dout,
  output logic         last_bit
);
  localparam int unsigned BW = $clog2(W + 1);

  logic [W-2:0] rest;
  logic [BW-1:0] bits;
  logic          dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rest   <= '1;
      bits   <= '0;
      dout_q <= 1'b1;
    end else if (load) begin
      rest   <= data[W-2:0];
      bits   <= BW'(W);
      dout_q <= data[W-1];
    end else if (shift) begin
      // ones fill in behind, so the line idles high after the word
      rest   <= {rest[W-3:0], 1'b1};
      dout_q <= rest[W-2];
      if (bits != '0) bits <= bits - 1'b1;
    end
  end

  assign dout     = dout_q;
  assign last_bit = (bits == BW'(1));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CLK_HZ       = 200_000_000,
  parameter int unsigned SETTLE_US    = 4,
  parameter int unsigned HALF_DIV     = 2,
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned DONE_TIMEOUT = 64,
  parameter int unsigned CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              cfg_init,
  input  logic              cfg_done,
  output logic              cfg_clk,
  output logic              cfg_dout,
  output logic              busy,
  output logic              ok,
  output logic              err,
  output logic              timeout,
  output logic [CNT_W-1:0]  word_cnt
);
  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_US);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam int unsigned FW = $clog2(DONE_TIMEOUT + 1);

  ld_state_t        state;
  logic [SW-1:0]    settle_cnt;
  logic [FW-1:0]    flush_cnt;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q;

  logic [1:0] sync_q;
  logic       init_s, done_s;
  logic       run, rise_evt, fall_evt, last_bit, accept, shift_en;

  cfg_sync #(.W(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cfg_done, cfg_init}),
    .q   (sync_q)
  );
  assign init_s = sync_q[0];
  assign done_s = sync_q[1];

  assign run = ((state == ST_SHIFT) || (state == ST_FLUSH)) && init_s && !start;

  cfg_pace #(.HALF_DIV(HALF_DIV)) u_pace (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .cfg_clk  (cfg_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  assign s_ready  = (state == ST_LOAD) && init_s && !start;
  assign accept   = s_ready && s_valid;
  assign shift_en = fall_evt && (state == ST_SHIFT);

  cfg_shifter #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .data     (s_data),
    .shift    (shift_en),
    .dout     (cfg_dout),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      settle_cnt <= '0;
      flush_cnt  <= '0;
      cnt_q      <= '0;
      last_q     <= 1'b0;
    end else if (start) begin
      state      <= ST_WAIT_INIT;
      settle_cnt <= '0;
      flush_cnt  <= '0;
      cnt_q      <= '0;
      last_q     <= 1'b0;
    end else begin
      unique case (state)
        ST_WAIT_INIT: begin
          if (init_s) begin
            state      <= ST_SETTLE;
            settle_cnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (!init_s) state <= ST_WAIT_INIT;
          else if (settle_cnt == SW'(SETTLE_CYC - 1)) state <= ST_LOAD;
          else settle_cnt <= settle_cnt + 1'b1;
        end
        ST_LOAD: begin
          if (!init_s) state <= ST_FAULT;
          else if (accept) begin
            state  <= ST_SHIFT;
            last_q <= s_last;
            cnt_q  <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (!init_s) state <= ST_FAULT;
          else if (fall_evt && last_bit) begin
            state     <= last_q ? ST_FLUSH : ST_LOAD;
            flush_cnt <= '0;
          end
        end
        ST_FLUSH: begin
          if (!init_s) state <= ST_FAULT;
          else if (fall_evt) begin
            if (done_s) state <= ST_FIN_OK;
            else if (flush_cnt == FW'(DONE_TIMEOUT - 1)) state <= ST_FIN_TO;
            else flush_cnt <= flush_cnt + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

  assign busy     = (state == ST_WAIT_INIT) || (state == ST_SETTLE) || (state == ST_LOAD) ||
                    (state == ST_SHIFT) || (state == ST_FLUSH);
  assign ok       = (state == ST_FIN_OK);
  assign timeout  = (state == ST_FIN_TO);
  assign err      = (state == ST_FAULT);
  assign word_cnt = cnt_q;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cfg_init,
  input logic cfg_clk,
  input logic cfg_dout,
  input logic s_ready,
  input logic busy,
  input logic ok,
  input logic err,
  input logic timeout
);
  logic seen_init;

  always_ff @(posedge clk) begin
    if (rst || start) seen_init <= 1'b0;
    else if (cfg_init) seen_init <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cfg_clk && !s_ready && !busy && !ok && !err && !timeout));

  assert_no_edge_before_init_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_clk) |-> seen_init);

  assert_data_stable_high_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_clk |-> $stable(cfg_dout));

  assert_ready_clock_low_R6: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> !cfg_clk);

  assert_fault_stops_clock_R7: assert property (@(posedge clk) disable iff (rst)
    err |=> !cfg_clk);

  assert_fault_latched_R8: assert property (@(posedge clk) disable iff (rst)
    (err && !start) |=> err);

  assert_status_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ok, err, timeout}));

  assert_timeout_latched_R10: assert property (@(posedge clk) disable iff (rst)
    (timeout && !start) |=> timeout);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .cfg_init (cfg_init),
  .cfg_clk  (cfg_clk),
  .cfg_dout (cfg_dout),
  .s_ready  (s_ready),
  .busy     (busy),
  .ok       (ok),
  .err      (err),
  .timeout  (timeout)
);

// File: tb/test_cfg_serial_loader.sv
`timescale 1ns/1ps
module test_cfg_serial_loader;
  localparam int unsigned CLK_HZ       = 200_000_000;
  localparam int unsigned SETTLE_US    = 4;
  localparam int unsigned HALF_DIV     = 2;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned DONE_TIMEOUT = 64;
  localparam int unsigned CNT_W        = 16;
  localparam int SETTLE_CYC = ((CLK_HZ + 999_999) / 1_000_000) * SETTLE_US;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [WORD_W-1:0] s_data = '0;
  logic cfg_init = 1'b0, cfg_done = 1'b0;
  logic s_ready, cfg_clk, cfg_dout, busy, ok, err, timeout;
  logic [CNT_W-1:0] word_cnt;

  always #2.5 clk = ~clk;

  cfg_serial_loader #(
    .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .HALF_DIV(HALF_DIV),
    .WORD_W(WORD_W), .DONE_TIMEOUT(DONE_TIMEOUT), .CNT_W(CNT_W)
  ) i_cfg_serial_loader (
    .clk(clk), .rst(rst), .start(start), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .s_ready(s_ready), .cfg_init(cfg_init), .cfg_done(cfg_done),
    .cfg_clk(cfg_clk), .cfg_dout(cfg_dout), .busy(busy), .ok(ok), .err(err),
    .timeout(timeout), .word_cnt(word_cnt)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  bit rx_bits [0:8191];
  int rx_n = 0, rise_cnt = 0;
  int viol_r2 = 0, viol_r3 = 0, viol_r5 = 0;
  bit init_seen = 0, first_pend = 0;
  int ref_cyc = 0, last_rise_cyc = -1000, prev_acc_rise = 0;
  logic prev_clk = 1'b0, prev_dout = 1'b1;
  logic [WORD_W-1:0] sent [0:255];
  int sent_n = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // edge monitor, sampled half a cycle away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (cfg_init && !init_seen) begin
        init_seen = 1;
        ref_cyc = cyc;
      end
      if (cfg_clk && !prev_clk) begin
        if (!init_seen) viol_r2++;
        if (first_pend) begin
          if (cyc - ref_cyc < SETTLE_CYC) viol_r3++;
          first_pend = 0;
        end
        if (cyc - last_rise_cyc < 2 * HALF_DIV) viol_r5++;
        last_rise_cyc = cyc;
        if (rx_n < 8192) rx_bits[rx_n] = cfg_dout;
        rx_n++;
        rise_cnt++;
      end
      if (cfg_clk && (cfg_dout !== prev_dout)) viol_r5++;
    end
    prev_clk = cfg_clk;
    prev_dout = cfg_dout;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  task automatic drive_start();
    @(posedge clk); #1;
    start = 1'b1;
    init_seen = 0;
    first_pend = 1;
    rx_n = 0;
    rise_cnt = 0;
    sent_n = 0;
    prev_acc_rise = 0;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic send_word(input logic [WORD_W-1:0] d, input bit last);
    s_valid = 1'b1;
    s_data = d;
    s_last = last;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk); #1;
    s_valid = 1'b0;
    s_last = 1'b0;
    if (sent_n > 0) chk("R6 rises between accepts", rise_cnt - prev_acc_rise, WORD_W);
    prev_acc_rise = rise_cnt;
    sent[sent_n] = d;
    sent_n++;
  endtask

  task automatic wait_fin();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ok || err || timeout) break;
    end
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rise_cnt >= n) break;
    end
  endtask

  function automatic logic [WORD_W-1:0] rx_word(input int w);
    logic [WORD_W-1:0] v;
    for (int i = 0; i < WORD_W; i++) v[WORD_W-1-i] = rx_bits[w * WORD_W + i];
    return v;
  endfunction

  task automatic check_stream();
    int ones_bad;
    for (int w = 0; w < sent_n; w++) chk("R4 word MSB first", rx_word(w), sent[w]);
    ones_bad = 0;
    for (int i = sent_n * WORD_W; i < rx_n; i++) if (rx_bits[i] !== 1'b1) ones_bad++;
    chk("R9 flush data high", ones_bad, 0);
    chk("R6 word_cnt", word_cnt, sent_n);
  endtask

  initial begin
    int r0;
    void'($urandom(32'd4711));
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfg_clk", cfg_clk, 0);
    chk("R1 cfg_dout", cfg_dout, 1);
    chk("R1 s_ready", s_ready, 0);
    chk("R1 status", {busy, ok, err, timeout}, 0);
    chk("R1 word_cnt", word_cnt, 0);

    // R2: init held low, no clocking
    drive_start();
    repeat (300) @(negedge clk);
    chk("R2 no rise while init low", rise_cnt, 0);
    chk("R2 no ready while init low", s_ready, 0);
    chk("R11 busy after start", busy, 1);
    @(posedge clk); #1 cfg_init = 1'b1;

    // directed stream with done
    send_word(32'h0000_0000, 0);
    send_word(32'hFFFF_FFFF, 0);
    send_word(32'h8000_0001, 0);
    send_word(32'h7FFF_FFFE, 0);
    send_word(32'hA5C3_0F96, 1);
    wait_rises(5 * WORD_W + 3);
    @(posedge clk); #1 cfg_done = 1'b1;
    wait_fin();
    chk("R9 ok after done", {ok, err, timeout}, 3'b100);
    chk("R9 not busy", busy, 0);
    check_stream();
    chk("R2 edges before init", viol_r2, 0);
    chk("R3 settle before first edge", viol_r3, 0);
    chk("R5 data stable and period", viol_r5, 0);

    // R11 restart clears status; R10 timeout with done low
    #1 cfg_done = 1'b0;
    drive_start();
    @(negedge clk);
    chk("R11 ok cleared", ok, 0);
    chk("R11 word_cnt cleared", word_cnt, 0);
    chk("R11 busy", busy, 1);
    for (int w = 0; w < 3; w++) begin
      repeat ($urandom % 7) @(posedge clk);
      #1;
      send_word($urandom, w == 2);
    end
    wait_fin();
    chk("R10 timeout flag", {ok, err, timeout}, 3'b001);
    chk("R10 flush pulses", rx_n - 3 * WORD_W, DONE_TIMEOUT);
    check_stream();
    repeat (20) @(negedge clk);
    chk("R10 timeout held", timeout, 1);

    // R7/R8: init falls mid word
    drive_start();
    send_word($urandom, 0);
    send_word($urandom, 0);
    wait_rises(WORD_W + 1 + ($urandom % 28));
    @(posedge clk); #1 cfg_init = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 err on init low", err, 1);
    chk("R7 not busy", busy, 0);
    chk("R7 not ready", s_ready, 0);
    r0 = rise_cnt;
    repeat (200) @(negedge clk);
    chk("R7 no more edges", rise_cnt, r0);
    chk("R7 clock low", cfg_clk, 0);
    @(posedge clk); #1 cfg_init = 1'b1;
    repeat (50) @(negedge clk);
    chk("R8 err latched", err, 1);
    chk("R8 still no edges", rise_cnt, r0);

    // random streams
    for (int it = 0; it < 4; it++) begin
      int n;
      n = 1 + ($urandom % 5);
      drive_start();
      @(negedge clk);
      chk("R8 err cleared by start", err, 0);
      for (int w = 0; w < n; w++) begin
        repeat ($urandom % 9) @(posedge clk);
        #1;
        send_word($urandom, w == n - 1);
      end
      wait_rises(n * WORD_W + 1 + ($urandom % 20));
      @(posedge clk); #1 cfg_done = 1'b1;
      wait_fin();
      chk("R9 ok random stream", {ok, err, timeout}, 3'b100);
      check_stream();
      #1 cfg_done = 1'b0;
    end
    chk("R2 edges before init final", viol_r2, 0);
    chk("R3 settle final", viol_r3, 0);
    chk("R5 stability final", viol_r5, 0);

    summary();
    $finish;
  end
endmodule